// File: doc/BRIEF.md
# UART Transmit Framer

This block turns queued characters into asynchronous serial frames on one output line. A small set of line-control inputs chooses the frame shape: five to eight data bits, no parity, computed even or odd parity, or a parity bit held at a fixed level, and one or two stop bits. A break request holds the line low once the character on the wire has been sent. Bit timing comes from an external tick that pulses sixteen times per bit period. The block does not generate that tick.

Characters arrive through a valid/ready handshake and wait in a holding stage. With the queue-mode input low, the stage takes one character at a time. With it high, the stage becomes a shallow first-in first-out queue of `FIFO_DEPTH` entries. A sequencer built around an enumerated state machine takes characters from this stage.

The states are IDLE, START, DATA, PARITY, STOP, BREAK and RECOVER. These are the transitions:
- IDLE→BREAK: on a tick while break is requested.
- IDLE→START: on a tick with a character waiting and no break request.
- START→DATA: after one bit period.
- DATA→DATA: after each data bit except the last.
- DATA→PARITY: after the last data bit when parity is on.
- DATA→STOP: after the last data bit when parity is off.
- PARITY→STOP: after one bit period.
- STOP→STOP: after the first of two stop bits.
- STOP→BREAK, STOP→START or STOP→IDLE: at the end of the last stop bit, chosen in that order of priority.
- BREAK→RECOVER: on a tick with the break request gone.
- RECOVER→IDLE: after one bit period.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `in_ready` is 1. Whenever `busy` is 0, `txd` is 1.
- R2: A frame consists of these bits, in this order:
  - a start bit at 0;
  - the data bits, bit 0 first;
  - the parity bit, if parity is on;
  - the stop bit(s) at 1.

  Each bit lasts exactly 16 ticks. `txd` changes only on the clock edge that follows a cycle with `tick16` high.
- R3: `cfg_wlen` sets the number of data bits: 0→5, 1→6, 2→7, 3→8. Data bits above that count are not sent.
- R4: With `cfg_par_en`=0, the first stop bit follows the last data bit directly.
- R5: With `cfg_par_en`=1 and `cfg_stick`=0, a parity bit is sent. With `cfg_even`=1 the count of ones over the data and parity bits is even; with `cfg_even`=0 it is odd.
- R6: With `cfg_par_en`=1 and `cfg_stick`=1, the parity bit is 0 when `cfg_even`=1 and 1 when `cfg_even`=0.
- R7: With `cfg_stop2`=1 the frame ends with two stop bits; with `cfg_stop2`=0 it ends with one.
- R8: A break request (`cfg_break`=1) does not cut a frame short. When the frame ends, or on the next tick if the line is idle, `txd` goes to 0 and `busy` to 1, and both stay that way while the request lasts. A break takes priority over waiting characters.
- R9: After the break request is removed, the next tick drives `txd` to 1 for one bit period (16 ticks) with `busy` still 1. The block then returns to idle, and any waiting character starts on the following tick.
- R10: When `cfg_fifo_en`=0, `in_ready` is 1 only while the holding stage is empty. When `cfg_fifo_en`=1, `in_ready` is 1 while fewer than `FIFO_DEPTH` characters are held. A character is accepted on an edge with both `in_valid` and `in_ready` high, and characters are sent in the order they were accepted.
- R11: The data length, parity, stop-bit settings and character are captured on the tick that begins the start bit. Changing `cfg_*` during a frame has no effect on that frame.
- R12: `busy` is 1 from the start bit through the last stop bit, and during BREAK and RECOVER. When a character is waiting at the end of the last stop bit, the next start bit follows immediately and `busy` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling tick, sixteen per bit period |
| cfg_wlen | input | 2 | Data length code (0..3 selects 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_even | input | 1 | Even parity select; in stick mode, selects a 0 parity bit |
| cfg_stick | input | 1 | Parity bit held at a fixed level |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_break | input | 1 | Break request |
| cfg_fifo_en | input | 1 | Queue mode for the holding stage |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character; low bits are used for short lengths |
| in_ready | output | 1 | Holding stage can accept a character |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame, break or recovery in progress |

## Verification
A decision made on a tick edge shows on `txd` and `busy` in the cycle after that edge, because both outputs are decoded from registered state. An accepted character changes `in_ready` one cycle after its handshake edge. The bench model applies each decision at the same rising edge, using input values that are stable there. It compares all three outputs at every falling edge, so each result is checked in the exact cycle it is due. A bit that is one tick early or late therefore shows up as a miscompare.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int unsigned MAX_BITS = 8;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_START   = 3'd1,
        S_DATA    = 3'd2,
        S_PARITY  = 3'd3,
        S_STOP    = 3'd4,
        S_BREAK   = 3'd5,
        S_RECOVER = 3'd6
    } tx_state_e;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             in_valid,
    input  logic [W-1:0]     in_data,
    output logic             in_ready,
    input  logic             pop,
    output logic             have_char,
    output logic [W-1:0]     out_data,
    output logic [CNT_W-1:0] fill
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    // With queue mode off, only one character may be held at a time.
    always_comb begin
        if (fifo_en) begin
            in_ready = (count < CNT_W'(DEPTH));
        end else begin
            in_ready = (count == '0);
        end
    end

    assign push      = in_valid && in_ready;
    assign have_char = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign fill      = count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= in_data;
        end
    end

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] data,
    input  logic [1:0]   wlen,
    input  logic         even_sel,
    input  logic         stick,
    output logic         par_bit
);

    logic [W-1:0] masked;
    logic         ones_odd;

    // Keep only the bits the current length will send.
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign masked[i] = data[i] && (i < (5 + int'(wlen)));
    end

    assign ones_odd = ^masked;

    always_comb begin
        if (stick) begin
            par_bit = !even_sel;
        end else if (even_sel) begin
            par_bit = ones_odd;
        end else begin
            par_bit = !ones_odd;
        end
    end

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
    import uart_tx_pkg::*;
#(
    parameter int unsigned OVS = 16,
    localparam int unsigned TICK_W = $clog2(OVS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [1:0]          wlen,
    input  logic                par_en,
    input  logic                stop2,
    input  logic                par_in,
    input  logic                brk,
    input  logic                have_char,
    input  logic [MAX_BITS-1:0] char_data,
    output logic                pop,
    output logic                txd,
    output logic                busy
);

    tx_state_e           state, state_d;
    logic [TICK_W-1:0]   tcnt, tcnt_d;
    logic [2:0]          bit_idx, bit_idx_d;
    logic [2:0]          last_idx, last_idx_d;
    logic [MAX_BITS-1:0] shreg, shreg_d;
    logic                par_bit_q, par_bit_d;
    logic                par_en_q, par_en_d;
    logic                stop2_q, stop2_d;
    logic                stop_idx, stop_idx_d;
    logic                bit_end;

    assign bit_end = tick && (tcnt == TICK_W'(OVS - 1));

    // Next-state logic
    always_comb begin
        state_d    = state;
        tcnt_d     = tcnt;
        bit_idx_d  = bit_idx;
        last_idx_d = last_idx;
        shreg_d    = shreg;
        par_bit_d  = par_bit_q;
        par_en_d   = par_en_q;
        stop2_d    = stop2_q;
        stop_idx_d = stop_idx;
        pop        = 1'b0;

        if (tick && state != S_IDLE && state != S_BREAK) begin
            tcnt_d = bit_end ? '0 : tcnt + 1'b1;
        end

        unique case (state)
            S_IDLE: begin
                if (tick) begin
                    if (brk) begin
                        state_d = S_BREAK;
                    end else if (have_char) begin
                        state_d = S_START;
                        pop     = 1'b1;
                    end
                end
            end
            S_START: begin
                if (bit_end) begin
                    state_d   = S_DATA;
                    bit_idx_d = '0;
                end
            end
            S_DATA: begin
                if (bit_end) begin
                    shreg_d = shreg >> 1;
                    if (bit_idx == last_idx) begin
                        stop_idx_d = 1'b0;
                        state_d    = par_en_q ? S_PARITY : S_STOP;
                    end else begin
                        bit_idx_d = bit_idx + 1'b1;
                    end
                end
            end
            S_PARITY: begin
                if (bit_end) begin
                    state_d    = S_STOP;
                    stop_idx_d = 1'b0;
                end
            end
            S_STOP: begin
                if (bit_end) begin
                    if (stop2_q && !stop_idx) begin
                        stop_idx_d = 1'b1;
                    end else if (brk) begin
                        state_d = S_BREAK;
                    end else if (have_char) begin
                        state_d = S_START;
                        pop     = 1'b1;
                    end else begin
                        state_d = S_IDLE;
                    end
                end
            end
            S_BREAK: begin
                if (tick && !brk) begin
                    state_d = S_RECOVER;
                    tcnt_d  = '0;
                end
            end
            S_RECOVER: begin
                if (bit_end) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase

        // Frame launch: capture the character and line settings.
        if (pop) begin
            tcnt_d     = '0;
            shreg_d    = char_data;
            last_idx_d = 3'd4 + {1'b0, wlen};
            par_bit_d  = par_in;
            par_en_d   = par_en;
            stop2_d    = stop2;
            bit_idx_d  = '0;
            stop_idx_d = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            tcnt      <= '0;
            bit_idx   <= '0;
            last_idx  <= '0;
            shreg     <= '0;
            par_bit_q <= 1'b0;
            par_en_q  <= 1'b0;
            stop2_q   <= 1'b0;
            stop_idx  <= 1'b0;
        end else begin
            state     <= state_d;
            tcnt      <= tcnt_d;
            bit_idx   <= bit_idx_d;
            last_idx  <= last_idx_d;
            shreg     <= shreg_d;
            par_bit_q <= par_bit_d;
            par_en_q  <= par_en_d;
            stop2_q   <= stop2_d;
            stop_idx  <= stop_idx_d;
        end
    end

    // Outputs
    always_comb begin
        txd  = 1'b1;
        busy = 1'b1;
        unique case (state)
            S_IDLE:    busy = 1'b0;
            S_START:   txd  = 1'b0;
            S_DATA:    txd  = shreg[0];
            S_PARITY:  txd  = par_bit_q;
            S_STOP:    txd  = 1'b1;
            S_BREAK:   txd  = 1'b0;
            S_RECOVER: txd  = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned OVS        = 16,
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick16,
    input  logic [1:0]          cfg_wlen,
    input  logic                cfg_par_en,
    input  logic                cfg_even,
    input  logic                cfg_stick,
    input  logic                cfg_stop2,
    input  logic                cfg_break,
    input  logic                cfg_fifo_en,
    input  logic                in_valid,
    input  logic [MAX_BITS-1:0] in_data,
    output logic                in_ready,
    output logic                txd,
    output logic                busy
);

    logic                pop;
    logic                have_char;
    logic [MAX_BITS-1:0] head_data;
    logic                par_calc;
    logic [CNT_W-1:0]    hold_fill;

    uart_tx_hold #(
        .DEPTH (FIFO_DEPTH),
        .W     (MAX_BITS)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (cfg_fifo_en),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .pop       (pop),
        .have_char (have_char),
        .out_data  (head_data),
        .fill      (hold_fill)
    );

    uart_tx_parity #(
        .W (MAX_BITS)
    ) u_par (
        .data     (head_data),
        .wlen     (cfg_wlen),
        .even_sel (cfg_even),
        .stick    (cfg_stick),
        .par_bit  (par_calc)
    );

    uart_tx_seq #(
        .OVS (OVS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .wlen      (cfg_wlen),
        .par_en    (cfg_par_en),
        .stop2     (cfg_stop2),
        .par_in    (par_calc),
        .brk       (cfg_break),
        .have_char (have_char),
        .char_data (head_data),
        .pop       (pop),
        .txd       (txd),
        .busy      (busy)
    );

endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick16,
    input logic             cfg_break,
    input logic             cfg_fifo_en,
    input logic             in_valid,
    input logic             in_ready,
    input logic             txd,
    input logic             busy,
    input logic [CNT_W-1:0] hold_fill
);

    // R1: an idle line sits high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R2: the line moves only after a tick edge
    p_edge_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(tick16));

    // R2: activity always opens with a low level
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    // R8: break requested on an idle line takes effect on the tick
    p_break_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_break && !busy && tick16) |=> (busy && !txd));

    // R10: single-entry mode takes one character at a time
    p_single_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fifo_en && in_valid && in_ready) |=> (!in_ready || cfg_fifo_en));

    // R10: a full queue refuses more
    p_full_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_fill == CNT_W'(DEPTH)) |-> !in_ready);

    // R10: the queue never holds more than its depth
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_fill <= CNT_W'(DEPTH));

endmodule

bind uart_tx_framer uart_tx_checker #(
    .DEPTH (FIFO_DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick16      (tick16),
    .cfg_break   (cfg_break),
    .cfg_fifo_en (cfg_fifo_en),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .txd         (txd),
    .busy        (busy),
    .hold_fill   (hold_fill)
);

// File: tb/tb_uart_tx_framer.sv
`timescale 1ns/1ps
module tb_uart_tx_framer;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [1:0] cfg_wlen = 2'd0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_even = 1'b0;
    logic       cfg_stick = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_break = 1'b0;
    logic       cfg_fifo_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       txd;
    logic       busy;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    uart_tx_framer #(.FIFO_DEPTH(DEPTH), .OVS(16)) dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_even(cfg_even),
        .cfg_stick(cfg_stick), .cfg_stop2(cfg_stop2), .cfg_break(cfg_break),
        .cfg_fifo_en(cfg_fifo_en), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .txd(txd), .busy(busy)
    );

    always #4 clk = ~clk;

    // Reference model. Modes: 0 idle, 1 frame, 2 break, 3 recovery.
    int  m_mode = 0;
    int  m_tcnt = 0;
    bit  m_bits[$];
    int  m_tags[$];
    byte m_chars[$];

    function automatic bit exp_ready();
        if (cfg_fifo_en) return (m_chars.size() < DEPTH);
        return (m_chars.size() == 0);
    endfunction

    function automatic bit exp_txd();
        if (m_mode == 1) return m_bits[0];
        if (m_mode == 2) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int exp_tag();
        if (m_mode == 1) return m_tags[0];
        if (m_mode == 2) return 8;
        if (m_mode == 3) return 9;
        return 1;
    endfunction

    function automatic void build_frame(input byte d);
        int n;
        int ones;
        bit p;
        n    = 5 + int'(cfg_wlen);   // R3 length code
        ones = 0;
        m_bits.push_back(1'b0); m_tags.push_back(2);
        for (int i = 0; i < n; i++) begin
            m_bits.push_back(d[i]); m_tags.push_back(3);
            ones += int'(d[i]);
        end
        if (cfg_par_en) begin
            if (cfg_stick) begin
                p = !cfg_even;                          // R6 fixed level
                m_tags.push_back(6);
            end else begin
                p = cfg_even ? ones[0] : !ones[0];      // R5 computed
                m_tags.push_back(5);
            end
            m_bits.push_back(p);
            m_bits.push_back(1'b1); m_tags.push_back(2);
        end else begin
            m_bits.push_back(1'b1); m_tags.push_back(4); // R4 stop follows data
        end
        if (cfg_stop2) begin
            m_bits.push_back(1'b1); m_tags.push_back(7); // R7 second stop
        end
    endfunction

    function automatic void next_frame();
        if (cfg_break) begin
            m_mode = 2;
        end else if (m_chars.size() > 0) begin
            build_frame(m_chars.pop_front());
            m_mode = 1;
            m_tcnt = 0;
        end else begin
            m_mode = 0;
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_tcnt = 0;
            m_bits.delete(); m_tags.delete(); m_chars.delete();
        end else begin
            bit  psh;
            byte pd;
            psh = in_valid && exp_ready();
            pd  = in_data;
            case (m_mode)
                0: if (tick16) next_frame();
                1: if (tick16) begin
                    m_tcnt++;
                    if (m_tcnt == 16) begin
                        m_tcnt = 0;
                        void'(m_bits.pop_front());
                        void'(m_tags.pop_front());
                        if (m_bits.size() == 0) next_frame();   // R12 back to back
                    end
                end
                2: if (tick16 && !cfg_break) begin m_mode = 3; m_tcnt = 0; end
                default: if (tick16) begin
                    m_tcnt++;
                    if (m_tcnt == 16) m_mode = 0;
                end
            endcase
            if (psh) m_chars.push_back(pd);
        end
    end

    // Comparison on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (txd !== exp_txd()) begin
                errors++;
                $display("FAIL R%0d txd actual=%b expected=%b t=%0t", exp_tag(), txd, exp_txd(), $time);
            end
            if (busy !== (m_mode != 0)) begin
                errors++;   // R12
                $display("FAIL R12 busy actual=%b expected=%b t=%0t", busy, (m_mode != 0), $time);
            end
            if (in_ready !== exp_ready()) begin
                errors++;   // R10
                $display("FAIL R10 in_ready actual=%b expected=%b t=%0t", in_ready, exp_ready(), $time);
            end
        end
    end

    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            tick16 = (c % 2 == 0);
            c++;
        end
    end

    task automatic send(input byte d);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        while (!(m_mode == 0 && m_chars.size() == 0)) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] wl, input bit pe, input bit ev,
                           input bit st, input bit s2);
        cfg_wlen = wl; cfg_par_en = pe; cfg_even = ev; cfg_stick = st; cfg_stop2 = s2;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        vectors++;
        if (txd !== 1'b1 || busy !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset txd/busy/ready actual=%b%b%b expected=101", txd, busy, in_ready);
        end
        repeat (5) @(negedge clk);

        // R2 R3 R4: each length code, no parity, one stop
        for (int w = 0; w < 4; w++) begin
            set_cfg(2'(w), 1'b0, 1'b0, 1'b0, 1'b0);
            send(8'hA5 ^ 8'(w * 37));
            wait_quiet();
        end
        // R5: computed even and odd parity
        set_cfg(2'd3, 1'b1, 1'b1, 1'b0, 1'b0); send(8'h96); wait_quiet();
        set_cfg(2'd3, 1'b1, 1'b0, 1'b0, 1'b0); send(8'h96); wait_quiet();
        set_cfg(2'd1, 1'b1, 1'b1, 1'b0, 1'b0); send(8'hF7); wait_quiet();
        set_cfg(2'd0, 1'b1, 1'b0, 1'b0, 1'b0); send(8'h03); wait_quiet();
        // R6: fixed parity levels
        set_cfg(2'd2, 1'b1, 1'b1, 1'b1, 1'b0); send(8'h7F); wait_quiet();
        set_cfg(2'd2, 1'b1, 1'b0, 1'b1, 1'b0); send(8'h00); wait_quiet();
        // R7: two stop bits
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b1); send(8'h81); wait_quiet();
        set_cfg(2'd0, 1'b1, 1'b1, 1'b0, 1'b1); send(8'h1E); wait_quiet();

        // R10 R12: queue mode burst beyond depth, back-to-back frames
        cfg_fifo_en = 1'b1;
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) send(8'h30 + 8'(k));
        wait_quiet();
        // R10: single-entry mode with two characters queued behind
        cfg_fifo_en = 1'b0;
        send(8'h55); send(8'hAA); send(8'h0F);
        wait_quiet();

        // R11: settings changed mid-frame are ignored by that frame
        set_cfg(2'd3, 1'b1, 1'b1, 1'b0, 1'b1);
        send(8'hC3);
        repeat (100) @(negedge clk);
        set_cfg(2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        wait_quiet();

        // R8 R9: break raised during a frame, character queued during break
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'h5A);
        repeat (50) @(negedge clk);
        cfg_break = 1'b1;
        while (m_mode != 2) @(negedge clk);
        send(8'h33);
        repeat (600) @(negedge clk);
        cfg_break = 1'b0;
        wait_quiet();
        // R8: break on an idle line
        cfg_break = 1'b1;
        repeat (40) @(negedge clk);
        cfg_break = 1'b0;
        wait_quiet();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule